// File: doc/BRIEF.md
# Endian-Configurable Load/Store Aligner

This block sits between a processor datapath and a byte-addressed data memory whose port is one 64-bit slot wide. The datapath presents one request per cycle: a store or a load, an access size of one, two, four or eight bytes, a byte address, a signed/unsigned flag and the store data. Only the three low address bits pick bytes within the slot. One cycle later the block presents the result. For a store it gives a write strobe, per-byte enables and write data moved into the addressed byte lanes. For a load it gives the addressed bytes taken from the slot that memory returned, extended to 64 bits.

A mode input chooses the byte numbering. In little-endian mode the least significant byte of an object sits at its lowest address. In big-endian mode the most significant byte sits there. The lane pattern in big-endian mode is the byte mirror of little-endian mode within the slot. Any request whose address is not a whole multiple of its size is refused. Instead of the access, the block raises an alignment fault for one cycle.

Top module: `lsa_aligner`

## Requirements
- R1: While rst_n is low at a clock edge, every output is zero after that edge.
- R2: A request with req_addr[2:0] not a multiple of the access size in bytes (size code 0=1, 1=2, 2=4, 3=8 bytes) sets align_fault in the following cycle, with mem_we, ld_valid and every bit of mem_be low.
- R3: In little-endian mode (big_endian=0), an aligned store of n bytes at offset o=req_addr[2:0] sets mem_we and exactly the mem_be bits o through o+n-1 in the following cycle.
- R4: In big-endian mode (big_endian=1), an aligned store of n bytes at offset o sets exactly the mem_be bits 7-o-(n-1) through 7-o, which is the byte mirror of the little-endian pattern.
- R5: In little-endian mode, byte k (bits 8k+7:8k) of st_data for k<n appears on mem_wdata lane o+k, and all lanes with mem_be low read zero.
- R6: In big-endian mode, byte k of st_data for k<n appears on mem_wdata lane 7-(o+n-1-k), and all lanes with mem_be low read zero.
- R7: In little-endian mode, an aligned load sets ld_valid in the following cycle, and byte k of ld_data for k<n equals lane o+k of rd_slot.
- R8: In big-endian mode, byte k of ld_data for k<n equals lane 7-(o+n-1-k) of rd_slot.
- R9: ld_data bits above 8n are copies of bit 8n-1 when req_signed is high and zero when it is low.
- R10: A cycle with req_valid low is followed by a cycle with mem_we, ld_valid and align_fault all low, so a fault lasts one cycle per refused request.
- R11: A big-endian value stored at an address and then loaded back from the same address, with the slot updated under mem_be, returns the original value for every aligned size and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend the load result |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| req_addr | input | ADDR_W | Byte address of the access |
| big_endian | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| st_data | input | 64 | Store value, right-justified |
| rd_slot | input | 64 | Memory slot holding the load address |
| mem_we | output | 1 | Write strobe for the slot |
| mem_be | output | 8 | Per-lane byte enables |
| mem_wdata | output | 64 | Lane-placed write data |
| ld_valid | output | 1 | Load result is valid |
| ld_data | output | 64 | Extended load result |
| align_fault | output | 1 | The previous request was misaligned |

## Verification
The bench builds the block with its default parameters: a 64-bit slot of eight lanes and a 32-bit address. Eight lanes make a full sweep small. Every combination of endianness, access size, low address offset, direction and signedness is applied, so every aligned placement and every misaligned case is exercised. Expected lanes and extensions are worked out byte by byte from the address arithmetic. A big-endian write-then-read pass over all aligned words and other sizes confirms that values survive the round trip through the slot.

// File: rtl/lsa_pkg.sv
// Shared constants and types for the load/store aligner.
// Assumes a slot of eight byte lanes so that the largest size code fits.
package lsa_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;
endpackage

// File: rtl/lsa_access_check.sv
// Decodes size, lane offset and byte order into a legality flag, a
// right-justified byte mask and a lane shift count.
// Assumes LANES is a power of two and at least eight.
module lsa_access_check #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] offset,
    input  logic             big_endian,
    output logic             misaligned,
    output logic [LANES-1:0] low_mask,
    output logic [CNT_W-1:0] shift,
    output logic [CNT_W-1:0] nbytes
);
    // Number of bytes the size code names.
    always_comb begin
        nbytes = CNT_W'(1) << size;
    end

    // Legality: offset must be a multiple of the access size.
    always_comb begin
        misaligned = |(offset & OFF_W'(nbytes - CNT_W'(1)));
    end

    // Right-justified mask covering the first nbytes lanes.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            low_mask[i] = (i < int'(nbytes));
        end
    end

    // Lane shift: offset for little-endian, mirrored position for big-endian.
    always_comb begin
        if (misaligned) begin
            shift = '0;
        end else if (big_endian) begin
            shift = CNT_W'(LANES) - {1'b0, offset} - nbytes;
        end else begin
            shift = {1'b0, offset};
        end
    end
endmodule

// File: rtl/lsa_store_lanes.sv
// Places the low bytes of the store value into their lanes and builds
// the matching byte enables. Assumes shift+bytes never exceeds LANES.
module lsa_store_lanes #(
    parameter int LANES = 8,
    localparam int DATA_W = LANES * lsa_pkg::BYTE_W,
    localparam int CNT_W = $clog2(LANES) + 1
) (
    input  logic [DATA_W-1:0] st_data,
    input  logic [LANES-1:0]  low_mask,
    input  logic [CNT_W-1:0]  shift,
    output logic [DATA_W-1:0] lane_data,
    output logic [LANES-1:0]  lane_en
);
    logic [DATA_W-1:0] trimmed;

    // Zero the bytes beyond the access size.
    for (genvar i = 0; i < LANES; i++) begin : g_trim
        assign trimmed[i*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W] =
            low_mask[i] ? st_data[i*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W] : '0;
    end

    // Move data and enables up to the addressed lanes.
    always_comb begin
        lane_data = trimmed << {shift, 3'b000};
        lane_en   = low_mask << shift;
    end
endmodule

// File: rtl/lsa_load_extract.sv
// Pulls the addressed bytes out of a memory slot and extends them to
// the full slot width. Assumes nbytes is a power of two up to LANES.
module lsa_load_extract #(
    parameter int LANES = 8,
    localparam int DATA_W = LANES * lsa_pkg::BYTE_W,
    localparam int CNT_W = $clog2(LANES) + 1
) (
    input  logic [DATA_W-1:0] slot,
    input  logic [LANES-1:0]  low_mask,
    input  logic [CNT_W-1:0]  shift,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] justified;
    logic              top_bit;

    // Bring the addressed bytes down to lane zero.
    always_comb begin
        justified = slot >> {shift, 3'b000};
    end

    // Pick the most significant bit of the loaded object.
    always_comb begin
        top_bit = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (i == int'(nbytes) - 1) begin
                top_bit = justified[i*lsa_pkg::BYTE_W + lsa_pkg::BYTE_W - 1];
            end
        end
    end

    // Keep object bytes, fill the rest with the extension byte.
    for (genvar i = 0; i < LANES; i++) begin : g_fill
        assign value[i*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W] =
            low_mask[i] ? justified[i*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W]
                        : {lsa_pkg::BYTE_W{top_bit & sign_ext}};
    end
endmodule

// File: rtl/lsa_aligner.sv
// Load/store aligner for one byte-addressed memory slot with runtime
// byte-order selection. One register stage: every request is answered
// in the next cycle. Assumes rd_slot is the slot holding req_addr.
module lsa_aligner #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int DATA_W = LANES * lsa_pkg::BYTE_W,
    localparam int OFF_W = $clog2(LANES),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_signed,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_slot,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              align_fault
);
    logic             bad_align;
    logic [LANES-1:0] size_mask;
    logic [CNT_W-1:0] lane_shift;
    logic [CNT_W-1:0] obj_bytes;
    logic [DATA_W-1:0] placed_data;
    logic [LANES-1:0]  placed_en;
    logic [DATA_W-1:0] loaded_val;

    lsa_access_check #(.LANES(LANES)) u_check (
        .size       (req_size),
        .offset     (req_addr[OFF_W-1:0]),
        .big_endian (big_endian),
        .misaligned (bad_align),
        .low_mask   (size_mask),
        .shift      (lane_shift),
        .nbytes     (obj_bytes)
    );

    lsa_store_lanes #(.LANES(LANES)) u_store (
        .st_data   (st_data),
        .low_mask  (size_mask),
        .shift     (lane_shift),
        .lane_data (placed_data),
        .lane_en   (placed_en)
    );

    lsa_load_extract #(.LANES(LANES)) u_load (
        .slot     (rd_slot),
        .low_mask (size_mask),
        .shift    (lane_shift),
        .nbytes   (obj_bytes),
        .sign_ext (req_signed),
        .value    (loaded_val)
    );

    // Register the store side; enables only on a legal store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= req_valid && req_store && !bad_align;
            mem_be    <= (req_valid && req_store && !bad_align) ? placed_en : '0;
            mem_wdata <= (req_valid && req_store && !bad_align) ? placed_data : '0;
        end
    end

    // Register the load side and the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid    <= 1'b0;
            ld_data     <= '0;
            align_fault <= 1'b0;
        end else begin
            ld_valid    <= req_valid && !req_store && !bad_align;
            ld_data     <= (req_valid && !req_store && !bad_align) ? loaded_val : '0;
            align_fault <= req_valid && bad_align;
        end
    end
endmodule

// File: rtl/lsa_checker.sv
// Temporal checks on the aligner's ports, attached by bind.
module lsa_checker #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic              mem_we,
    input logic [LANES-1:0]  mem_be,
    input logic              ld_valid,
    input logic              align_fault
);
    // R2
    fault_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (mem_be == '0) && !mem_we && !ld_valid);

    // R3
    be_count_matches_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == (1 << $past(req_size))));

    // R10
    idle_gives_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mem_we && !ld_valid && !align_fault);

    // R7
    load_follows_load_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store |=> !mem_we && (mem_be == '0));

    // R5
    no_enables_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == '0));
endmodule

bind lsa_aligner lsa_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lsa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_store   (req_store),
    .req_size    (req_size),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .ld_valid    (ld_valid),
    .align_fault (align_fault)
);

// File: tb/test_lsa_aligner.sv
module test_lsa_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic        req_signed = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic        big_endian = 1'b0;
    logic [63:0] st_data = '0;
    logic [63:0] rd_slot = '0;
    logic        mem_we;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        ld_valid;
    logic [63:0] ld_data;
    logic        align_fault;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    lsa_aligner i_lsa_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_signed(req_signed), .req_size(req_size), .req_addr(req_addr),
        .big_endian(big_endian), .st_data(st_data), .rd_slot(rd_slot),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .align_fault(align_fault)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Lane that holds object byte k (k=0 least significant).
    function automatic int lane_of(int bige, int off, int n, int k);
        int addr_ofs;
        addr_ofs = bige ? (off + n - 1 - k) : (off + k);
        return bige ? (7 - addr_ofs) : addr_ofs;
    endfunction

    // Drive one request at the falling edge; result is sampled one cycle later.
    task automatic issue(input bit st, input bit sg, input int sz, input int off,
                         input bit bige, input logic [63:0] sd, input logic [63:0] slot);
        req_valid  = 1'b1;
        req_store  = st;
        req_signed = sg;
        req_size   = 2'(sz);
        req_addr   = 32'h0000_1000 | 32'(off);
        big_endian = bige;
        st_data    = sd;
        rd_slot    = slot;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats[2];
        pats[0] = 64'hF1E2D3C4B5A69788;
        pats[1] = 64'h0172635445362718;

        repeat (3) @(negedge clk);
        // R1 reset state
        check({mem_we, ld_valid, align_fault} == 3'b000 && mem_be == 0 &&
              mem_wdata == 0 && ld_data == 0, "R1", {mem_we, ld_valid, align_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int bige = 0; bige < 2; bige++)
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
        for (int p = 0; p < 2; p++)
        for (int st = 0; st < 2; st++)
        for (int sg = 0; sg < 2; sg++) begin
            int n;
            bit legal;
            logic [7:0]  ebe;
            logic [63:0] ewd;
            logic [63:0] eld;
            n = 1 << sz;
            legal = (off % n) == 0;
            issue(st[0], sg[0], sz, off, bige[0], pats[p], ~pats[p] ^ 64'h5A);
            if (!legal) begin
                check(align_fault && !mem_we && !ld_valid && mem_be == 0, "R2",
                      {align_fault, mem_we, ld_valid, mem_be}, 64'h400);
            end else if (st != 0) begin
                ebe = '0;
                ewd = '0;
                for (int k = 0; k < n; k++) begin
                    int ln;
                    ln = lane_of(bige, off, n, k);
                    ebe[ln] = 1'b1;
                    ewd[ln*8 +: 8] = pats[p][k*8 +: 8];
                end
                check(mem_we && !align_fault, bige ? "R4" : "R3",
                      {mem_we, align_fault}, 64'h2);
                check(mem_be == ebe, bige ? "R4" : "R3", mem_be, ebe);
                check(mem_wdata == ewd, bige ? "R6" : "R5", mem_wdata, ewd);
            end else begin
                logic [63:0] slot;
                slot = ~pats[p] ^ 64'h5A;
                eld = '0;
                for (int k = 0; k < n; k++)
                    eld[k*8 +: 8] = slot[lane_of(bige, off, n, k)*8 +: 8];
                if (sg != 0 && eld[8*n-1])
                    for (int b = 8*n; b < 64; b++) eld[b] = 1'b1;
                check(ld_valid && !mem_we, bige ? "R8" : "R7", {ld_valid, mem_we}, 64'h2);
                check(ld_data == eld, (n < 8) ? "R9" : (bige ? "R8" : "R7"), ld_data, eld);
            end
            // R10 idle cycle gives quiet outputs
            @(negedge clk);
            check(!mem_we && !ld_valid && !align_fault, "R10",
                  {mem_we, ld_valid, align_fault}, 0);
        end

        // R11 big-endian store then load back at the same address
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off += (1 << sz)) begin
            logic [63:0] mem_slot;
            logic [63:0] val;
            logic [63:0] msk;
            mem_slot = 64'hA5A5_A5A5_A5A5_A5A5;
            msk = (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 1);
            val = 64'h8123_4567_89AB_CDEF & msk;
            issue(1'b1, 1'b0, sz, off, 1'b1, val, '0);
            for (int b = 0; b < 8; b++)
                if (mem_be[b]) mem_slot[b*8 +: 8] = mem_wdata[b*8 +: 8];
            @(negedge clk);
            issue(1'b0, 1'b0, sz, off, 1'b1, '0, mem_slot);
            check(ld_valid && ld_data == val, "R11", ld_data, val);
            @(negedge clk);
        end

        // R1 reset clears a pending result
        issue(1'b1, 1'b0, 3, 0, 1'b0, 64'h1, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check(!mem_we && mem_be == 0 && mem_wdata == 0, "R1", mem_wdata, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule